// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Output Timing

This block buffers 18-bit words between two unrelated clock domains. A writer pushes words on the write clock, and a reader takes them on the read clock. The two clocks may run at any frequencies. The storage is a power-of-two register array. The write and read positions are kept as binary counters with one extra wrap bit. Each position crosses into the other domain as a Gray code through a two-stage synchronizer. Each side judges full or empty from its own position and the synchronized copy of the other side's position. Because the copy can only lag, the flags err on the safe side.

The output timing is chosen once, while the full reset is held. In standard timing, the reader must issue an explicit read to move the next word into the output register, and the flags report full and empty. In fall-through timing, the head word appears on the output by itself, and the flags report input-ready and output-ready. The write side follows valid/ready rules: a word is taken on a write-clock edge only when `in_valid` is high and the write flag shows space; otherwise the word is dropped and the writer must present it again. The read side uses `out_ready` as its read enable and is throttled by `out_flag`.

A partial reset empties the buffer and keeps the chosen timing. A retransmit input rewinds the read side to location zero, so every word written since the last reset is delivered again.

Top module: `dcf_top`

## Requirements
- R1: On a rising `wclk` edge with `in_valid` high and space available, `in_data` is stored; words leave in the order they were stored.
- R2: In standard timing, a rising `rclk` edge with `out_ready` high while not empty loads the next word into `out_data`. Otherwise `out_data` holds, so a word written into an empty FIFO does not reach `out_data` until such a read.
- R3: A write while full is ignored: the word is not stored and no stored word is altered.
- R4: In standard timing, a read while empty is ignored: `out_data` and the read position are unchanged.
- R5: `mode_sel` is sampled while `mrst_n` is low (0 = standard timing, 1 = fall-through timing). It has no effect at any other time.
- R6: In standard timing, `in_flag` = 1 means full (DEPTH words held) and `out_flag` = 1 means empty.
- R7: In fall-through timing, `in_flag` = 1 means space is available, and `out_flag` = 1 means `out_data` carries the oldest unread word. The FIFO holds DEPTH+1 words in this timing, counting the output register.
- R8: In fall-through timing, a word written into an empty FIFO appears on `out_data`, with `out_flag` rising, at the third rising `rclk` edge after the write edge, without `out_ready`. A rising `rclk` edge with `out_flag` and `out_ready` both high consumes it, and any later word then needs such a read.
- R9: While `mrst_n` is low at a domain's clock edge, that domain's position returns to zero and `out_data` becomes all zeros, which leaves the FIFO empty.
- R10: While `prst_n` is low, the same clearing as in R9 occurs, and the timing latched by the last full reset is kept.
- R11: `rt` high at a rising `rclk` edge rewinds reading to location zero and leaves the write side untouched. If no more than DEPTH words have been written since reset, all of them are delivered again. `rt` takes precedence over a read, and in the `rclk` cycle that follows `out_flag` shows empty (1 in standard timing, 0 in fall-through timing).
- R12: The flags are conservative: `out_flag` never shows data when none is held, and `in_flag` never shows space when none is free. Once both sides have been idle for several cycles of each clock, both flags match the true fill level.
- R13: The Gray-coded positions that cross domains change by at most one bit per clock edge. The only exception is the retransmit rewind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Full reset, active low, sampled by both clocks |
| prst_n | input | 1 | Partial reset, active low, keeps the timing choice |
| mode_sel | input | 1 | Timing choice, sampled during full reset: 0 standard, 1 fall-through |
| in_valid | input | 1 | Write request |
| in_data | input | DATA_W | Word to write |
| in_flag | output | 1 | Standard: full; fall-through: input ready |
| out_ready | input | 1 | Read enable |
| rt | input | 1 | Retransmit request, read clock domain |
| out_data | output | DATA_W | Output register |
| out_flag | output | 1 | Standard: empty; fall-through: output ready |

## Verification
The hardest situations to reach are the retransmit cases. In these, `rt` lands while words are still unread and the output register may already hold a word, and replay must restart at location zero while the writer's view of the read position jumps backwards. The bench gets there with a fresh reset, a short batch of writes, a partial drain and then a single `rt` pulse, in both timings. It then checks the forced-empty cycle and the full replay. Fill-to-capacity runs and mixed-rate streaming with random enables cover the full and empty boundaries, including the extra word of fall-through storage.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  // Output timing latched during full reset.
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } out_mode_e;

  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/dcf_sync.sv
// Multi-stage synchronizer for a Gray-coded position, with binary decode.
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    bin_out[W-1] = stg[STAGES-1][W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/dcf_mem.sv
// Behavioural register array: write on wclk, asynchronous read.
module dcf_mem #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-domain control: position, full detection, flag polarity.
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic      wclk,
  input  logic      mrst_n,
  input  logic      prst_n,
  input  logic      mode_sel,
  input  logic      in_valid,
  input  logic [AW:0] rbin_s,
  output logic      push,
  output logic [AW:0] wbin,
  output logic [AW:0] wgray,
  output out_mode_e mode,
  output logic      in_flag
);
  logic        rst;
  logic        full;
  logic [AW:0] wbin_nx;

  assign rst     = !mrst_n || !prst_n;
  assign full    = (wbin[AW] != rbin_s[AW]) && (wbin[AW-1:0] == rbin_s[AW-1:0]);
  assign push    = in_valid && !full;
  assign wbin_nx = wbin + 1'b1;

  always_ff @(posedge wclk) begin
    if (!mrst_n) mode <= out_mode_e'(mode_sel);
  end

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  assign in_flag = (mode == MODE_FWFT) ? !full : full;
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-domain control: position, output register, retransmit, flags.
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_sel,
  input  logic          out_ready,
  input  logic          rt,
  input  logic [AW:0]   wbin_s,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output out_mode_e     mode,
  output logic [DW-1:0] out_data,
  output logic          out_flag
);
  logic        rst;
  logic        rt_hold;
  logic        ovalid;
  logic        mem_empty;
  logic        fetch;
  logic [AW:0] rbin_nx;

  assign rst       = !mrst_n || !prst_n;
  assign mem_empty = (rbin == wbin_s) || rt_hold;
  assign rbin_nx   = rbin + 1'b1;

  always_comb begin
    if (mode == MODE_FWFT) fetch = !mem_empty && (!ovalid || out_ready);
    else                   fetch = !mem_empty && out_ready;
  end

  always_ff @(posedge rclk) begin
    if (!mrst_n) mode <= out_mode_e'(mode_sel);
  end

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      out_data <= '0;
      ovalid   <= 1'b0;
      rt_hold  <= 1'b0;
    end else if (rt) begin
      rbin    <= '0;
      rgray   <= '0;
      ovalid  <= 1'b0;
      rt_hold <= 1'b1;
    end else begin
      rt_hold <= 1'b0;
      if (fetch) begin
        rbin     <= rbin_nx;
        rgray    <= rbin_nx ^ (rbin_nx >> 1);
        out_data <= mem_rdata;
      end
      if (mode == MODE_FWFT) begin
        if (fetch)          ovalid <= 1'b1;
        else if (out_ready) ovalid <= 1'b0;
      end else begin
        ovalid <= 1'b0;
      end
    end
  end

  assign out_flag = (mode == MODE_FWFT) ? ovalid : mem_empty;
endmodule

// File: rtl/dcf_top.sv
module dcf_top
  import dcf_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 16
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              mode_sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_flag,
  input  logic              out_ready,
  input  logic              rt,
  output logic [DATA_W-1:0] out_data,
  output logic              out_flag
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              any_rst;
  logic              push;
  logic [AW:0]       wbin, wgray, rbin, rgray;
  logic [AW:0]       wbin_s, rbin_s;
  logic [DATA_W-1:0] mem_rdata;
  out_mode_e         wr_mode, rd_mode;

  assign any_rst = !mrst_n || !prst_n;

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .wclk    (wclk),
    .mrst_n  (mrst_n),
    .prst_n  (prst_n),
    .mode_sel(mode_sel),
    .in_valid(in_valid),
    .rbin_s  (rbin_s),
    .push    (push),
    .wbin    (wbin),
    .wgray   (wgray),
    .mode    (wr_mode),
    .in_flag (in_flag)
  );

  dcf_mem #(.DW(DATA_W), .AW(AW)) u_mem (
    .wclk (wclk),
    .we   (push),
    .waddr(wbin[AW-1:0]),
    .wdata(in_data),
    .raddr(rbin[AW-1:0]),
    .rdata(mem_rdata)
  );

  dcf_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk    (rclk),
    .rst    (any_rst),
    .gray_in(wgray),
    .bin_out(wbin_s)
  );

  dcf_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk    (wclk),
    .rst    (any_rst),
    .gray_in(rgray),
    .bin_out(rbin_s)
  );

  dcf_rd_ctl #(.DW(DATA_W), .AW(AW)) u_rd (
    .rclk     (rclk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .mode_sel (mode_sel),
    .out_ready(out_ready),
    .rt       (rt),
    .wbin_s   (wbin_s),
    .mem_rdata(mem_rdata),
    .rbin     (rbin),
    .rgray    (rgray),
    .mode     (rd_mode),
    .out_data (out_data),
    .out_flag (out_flag)
  );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int AW = 4,
  parameter int DW = 18
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          in_valid,
  input logic          in_flag,
  input logic          out_ready,
  input logic          rt,
  input logic          out_flag,
  input logic [DW-1:0] out_data,
  input logic          wr_mode,
  input logic          rd_mode,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rbin,
  input logic [AW:0]   rgray
);
  // R3: write attempted while the flag reports no space leaves the position alone
  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    (in_valid && (wr_mode ? !in_flag : in_flag)) |=> $stable(wbin));

  // R4: standard-timing read while empty changes nothing
  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    (!rd_mode && out_flag && out_ready && !rt) |=> ($stable(rbin) && $stable(out_data)));

  // R11: retransmit rewinds reading to location zero
  assert_rt_rewind_R11: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    rt |=> (rbin == '0));

  // R11: the cycle after retransmit shows empty
  assert_rt_flag_R11: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    rt |=> (rd_mode ? !out_flag : out_flag));

  // R9 and R10: either reset clears the write position
  assert_wr_reset_R9: assert property (@(posedge wclk)
    (!mrst_n || !prst_n) |=> (wbin == '0));

  // R10: either reset clears the read position and the output register
  assert_rd_reset_R10: assert property (@(posedge rclk)
    (!mrst_n || !prst_n) |=> ((rbin == '0) && (out_data == '0)));

  // R5: latched timing holds outside full reset
  assert_mode_hold_R5: assert property (@(posedge rclk) disable iff (!mrst_n)
    mrst_n |=> ($stable(rd_mode) && (rd_mode == wr_mode)));

  // R13: write Gray position steps by at most one bit
  assert_wgray_step_R13: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
    mrst_n |=> $onehot0(wgray ^ $past(wgray)));

  // R13: read Gray position steps by at most one bit except on rewind
  assert_rgray_step_R13: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
    !rt |=> $onehot0(rgray ^ $past(rgray)));
endmodule

bind dcf_top dcf_chk #(.AW(AW), .DW(DATA_W)) u_chk (
  .wclk     (wclk),
  .rclk     (rclk),
  .mrst_n   (mrst_n),
  .prst_n   (prst_n),
  .in_valid (in_valid),
  .in_flag  (in_flag),
  .out_ready(out_ready),
  .rt       (rt),
  .out_flag (out_flag),
  .out_data (out_data),
  .wr_mode  (wr_mode),
  .rd_mode  (rd_mode),
  .wbin     (wbin),
  .wgray    (wgray),
  .rbin     (rbin),
  .rgray    (rgray)
);

// File: tb/tb_dcf_top.sv
`timescale 1ns/100ps
module tb_dcf_top;
  localparam int DW    = 18;
  localparam int DEPTH = 16;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
  logic          in_valid = 1'b0, out_ready = 1'b0, rt = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_flag, out_flag;
  logic [DW-1:0] out_data;

  always #2 wclk = ~wclk;               // 250 MHz write clock
  initial begin #1.5; forever #3 rclk = ~rclk; end

  dcf_top #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_data(in_data), .in_flag(in_flag),
    .out_ready(out_ready), .rt(rt), .out_data(out_data), .out_flag(out_flag)
  );

  // Behavioural reference model
  logic [DW-1:0] hist [$];
  int            rd_idx = 0;
  bit            fwft_m = 1'b0;
  bit            model_on = 1'b0;
  logic [DW-1:0] exp_out = '0;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  function automatic int held();
    return hist.size() - rd_idx;
  endfunction

  function automatic int cap();
    return fwft_m ? DEPTH + 1 : DEPTH;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Write side: check flag safety, then commit the write taken at the next edge
  always @(negedge wclk) begin
    if (model_on && !done) begin
      bit space;
      space = fwft_m ? in_flag : !in_flag;
      if (space) chk(held() < cap(), "R12", "space shown while full", held(), cap() - 1);
      if (in_valid && space) hist.push_back(in_data);
    end
  end

  // Read side: compare output every cycle, then commit the read at the next edge
  always @(negedge rclk) begin
    if (model_on && !done) begin
      if (!fwft_m) begin
        chk(out_data == exp_out, "R2", "standard out_data", out_data, exp_out);
        if (!out_flag) chk(held() > 0, "R12", "data shown while empty", held(), 1);
        if (rt) rd_idx = 0;
        else if (out_ready && !out_flag && held() > 0) begin
          exp_out = hist[rd_idx];
          rd_idx++;
        end
      end else begin
        if (out_flag) begin
          chk(held() > 0, "R12", "output ready while empty", held(), 1);
          if (held() > 0) chk(out_data == hist[rd_idx], "R8", "fall-through head", out_data, hist[rd_idx]);
        end
        if (rt) rd_idx = 0;
        else if (out_flag && out_ready && held() > 0) rd_idx++;
      end
    end
  end

  task automatic do_reset(input bit full, input bit msel);
    @(posedge wclk); #1;
    model_on = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0; rt = 1'b0;
    mode_sel = msel;
    if (full) mrst_n = 1'b0; else prst_n = 1'b0;
    repeat (6) @(posedge rclk);
    @(posedge wclk); #1;
    hist.delete();
    rd_idx  = 0;
    exp_out = '0;
    if (full) fwft_m = msel;
    mrst_n = 1'b1; prst_n = 1'b1;
    model_on = 1'b1;
    repeat (4) @(posedge rclk);
  endtask

  task automatic write_burst(input int n, input int base, input bit rnd);
    @(posedge wclk); #1;
    for (int i = 0; i < n; i++) begin
      in_valid = rnd ? (($urandom % 3) != 0) : 1'b1;
      in_data  = DW'(base + i);
      @(posedge wclk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic read_cycles(input int n, input bit rnd);
    @(posedge rclk); #1;
    for (int i = 0; i < n; i++) begin
      out_ready = rnd ? (($urandom % 2) != 0) : 1'b1;
      @(posedge rclk); #1;
    end
    out_ready = 1'b0;
  endtask

  task automatic settle(input string req);
    repeat (10) @(posedge rclk);
    @(negedge wclk);
    chk(in_flag == (fwft_m ? (held() < cap()) : (held() >= cap())), req, "settled in_flag", in_flag, held());
    @(negedge rclk);
    chk(out_flag == (fwft_m ? (held() > 0) : (held() == 0)), req, "settled out_flag", out_flag, held());
  endtask

  task automatic pulse_rt(input string req);
    @(posedge rclk); #1; rt = 1'b1;
    @(posedge rclk); #1; rt = 1'b0;
    @(negedge rclk);
    chk(out_flag == !fwft_m, req, "flag after retransmit", out_flag, !fwft_m);
  endtask

  initial begin
    // Standard timing after full reset
    do_reset(1'b1, 1'b0);
    @(negedge rclk);
    chk(out_data == '0, "R9", "out_data after full reset", out_data, 0);
    chk(out_flag == 1'b1, "R6", "empty after reset", out_flag, 1);
    chk(in_flag == 1'b0, "R6", "not full after reset", in_flag, 0);

    write_burst(1, 'h155, 1'b0);
    settle("R6");
    chk(out_data == '0, "R2", "first word hidden until read", out_data, 0);
    read_cycles(1, 1'b0);
    @(negedge rclk);
    chk(out_data == DW'('h155), "R2", "word after read", out_data, 'h155);
    read_cycles(3, 1'b0);
    @(negedge rclk);
    chk(out_data == DW'('h155), "R4", "read while empty holds data", out_data, 'h155);

    // Fill past capacity, then drain
    write_burst(DEPTH + 4, 'h200, 1'b0);
    settle("R6");
    chk(held() == DEPTH, "R3", "words held after overfill", held(), DEPTH);
    read_cycles(DEPTH + 3, 1'b0);
    settle("R1");

    // Mixed-rate streaming
    fork
      write_burst(60, 'h1000, 1'b1);
      read_cycles(70, 1'b1);
    join
    read_cycles(DEPTH + 2, 1'b0);
    settle("R12");

    // Retransmit in standard timing
    do_reset(1'b1, 1'b0);
    write_burst(5, 'h300, 1'b0);
    settle("R6");
    read_cycles(3, 1'b0);
    pulse_rt("R11");
    settle("R11");
    chk(held() == 5, "R11", "words pending after rewind", held(), 5);
    read_cycles(6, 1'b0);
    settle("R11");
    chk(out_data == DW'('h304), "R11", "last replayed word", out_data, 'h304);

    // Fall-through timing
    do_reset(1'b1, 1'b1);
    @(negedge rclk);
    chk(out_flag == 1'b0, "R7", "not ready after reset", out_flag, 0);
    chk(in_flag == 1'b1, "R7", "input ready after reset", in_flag, 1);
    chk(out_data == '0, "R9", "out_data after full reset", out_data, 0);
    mode_sel = 1'b0;  // must have no effect now (R5)

    @(posedge wclk); #1; in_valid = 1'b1; in_data = DW'('h2aa);
    @(posedge wclk); #1; in_valid = 1'b0;
    @(posedge rclk); @(posedge rclk);
    @(negedge rclk);
    chk(out_flag == 1'b0, "R8", "not ready after two read edges", out_flag, 0);
    @(posedge rclk);
    @(negedge rclk);
    chk(out_flag == 1'b1, "R8", "ready at third read edge", out_flag, 1);
    chk(out_data == DW'('h2aa), "R8", "fall-through word", out_data, 'h2aa);
    write_burst(1, 'h2ab, 1'b0);
    settle("R7");
    chk(out_data == DW'('h2aa), "R8", "second word waits for read", out_data, 'h2aa);
    read_cycles(1, 1'b0);
    @(negedge rclk);
    chk(out_data == DW'('h2ab), "R8", "second word after read", out_data, 'h2ab);
    chk(out_flag == 1'b1, "R5", "timing kept after mode_sel change", out_flag, 1);

    read_cycles(1, 1'b0);
    write_burst(DEPTH + 4, 'h400, 1'b0);
    settle("R7");
    chk(held() == DEPTH + 1, "R7", "fall-through capacity", held(), DEPTH + 1);
    read_cycles(DEPTH + 3, 1'b0);
    settle("R7");
    fork
      write_burst(60, 'h2000, 1'b1);
      read_cycles(70, 1'b1);
    join
    read_cycles(DEPTH + 3, 1'b0);
    settle("R12");

    // Partial reset keeps fall-through timing
    do_reset(1'b0, 1'b0);
    @(negedge rclk);
    chk(out_data == '0, "R10", "out_data after partial reset", out_data, 0);
    chk(in_flag == 1'b1, "R10", "fall-through kept (input ready)", in_flag, 1);
    write_burst(4, 'h500, 1'b0);
    settle("R10");
    chk(out_flag == 1'b1, "R10", "word falls through after partial reset", out_flag, 1);

    // Retransmit in fall-through timing
    read_cycles(2, 1'b0);
    pulse_rt("R11");
    settle("R11");
    chk(out_data == DW'('h500), "R11", "replay restarts at first word", out_data, 'h500);
    read_cycles(5, 1'b0);
    settle("R11");

    // Full reset returns to standard timing
    do_reset(1'b1, 1'b0);
    @(negedge wclk);
    chk(in_flag == 1'b0, "R5", "standard timing after full reset", in_flag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule